// File: doc/BRIEF.md
# Strobed Input Handshake Port

This block is one 8-bit input channel of a parallel peripheral interface. An external device places a byte on the data pins and pulses an active-low strobe. While the strobe is low the block keeps loading the pins into a holding register, and it raises a buffer-full flag. This flag tells the device that the byte is waiting and the CPU has not yet taken it. Once the strobe has returned high, the block can also raise an interrupt request, provided its interrupt-enable flip-flop is set.

The CPU takes the byte with an active-low read strobe. The start of the read withdraws the interrupt. The end of the read drops the buffer-full flag, which tells the device it may send the next byte. The interrupt-enable flip-flop is loaded by a single-bit set/reset command that names one port C bit index. Only the index this channel owns has any effect. The channel places its interrupt, buffer-full and enable bits at fixed port C positions so that a CPU can poll them. One parameter selects the channel variant (A or B), and that choice fixes those bit positions.

All inputs are taken to be synchronous to `clk`. Decoding of the address and of control words happens outside this block.

Top module: `strobe_in_port`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears `ibf`, `intr`, `rd_data` and the interrupt enable. After that edge, `pc_bits` reads 0.
- R2: At each clock edge where `stb_n` is low, `rd_data` loads `pin_data`. After the strobe ends, `rd_data` keeps the value from the last low cycle, whatever the pins do next.
- R3: `ibf` is 1 after any clock edge at which `stb_n` was low. A second strobe while `ibf` is already 1 replaces the held byte and leaves `ibf` at 1.
- R4: `intr` is 1 only when all of the following hold: the strobe was high at the last edge, `ibf` is 1, the enable is 1, and the byte's strobe has completed. With the enable set, `intr` rises after the first edge that sees `stb_n` high again.
- R5: A falling edge of `rd_n` (1 at one clock edge, 0 at the next) clears `intr` after that edge. `ibf` stays 1 while `rd_n` is held low.
- R6: A rising edge of `rd_n` clears `ibf` after that edge, unless the strobe is low at the same edge.
- R7: A command with `cmd_we`=1 loads `cmd_val` into the enable only when `cmd_bit` equals the channel's enable index: 4 for variant A, 2 for variant B. Commands with any other index leave the enable unchanged.
- R8: `pc_bits` places the status bits by variant. For A: bit 3 = `intr`, bit 4 = enable, bit 5 = `ibf`. For B: bit 0 = `intr`, bit 1 = `ibf`, bit 2 = enable. `pc_own` is 1 on exactly those three bits, and every other bit of `pc_bits` is 0.
- R9: With the enable at 0, a completed strobe leaves `intr` at 0. If the byte is still unread and the enable is then set, `intr` rises after the command edge.
- R10: A new strobe going low while `intr` is 1 drops `intr` after that edge. `intr` rises again once that strobe completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_data | input | WIDTH | Data from the peripheral |
| stb_n | input | 1 | Peripheral strobe, active low |
| rd_n | input | 1 | CPU read strobe for this channel, active low |
| cmd_we | input | 1 | Bit set/reset command valid |
| cmd_bit | input | 3 | Port C bit index named by the command |
| cmd_val | input | 1 | Value the command writes |
| rd_data | output | WIDTH | Held byte presented to the CPU |
| ibf | output | 1 | Input buffer full |
| intr | output | 1 | Interrupt request, active high |
| pc_bits | output | 8 | This channel's status bits at their port C positions |
| pc_own | output | 8 | Mask of the port C bits this channel drives |

## Verification
The bench builds two instances with WIDTH=8, one as variant A and one as variant B, and drives both from the same stimulus. Because both instances see every set/reset command, a command at index 4 or 2 shows in the same run that one channel acts on it and the other ignores it. The two instances also show both status layouts side by side. The directed sequences cover data that changes within a single strobe, a strobe that overwrites an unread byte, a read held low for several cycles, and an interrupt unmasked while a byte is pending.

// File: rtl/strobe_in_pkg.sv
// Shared definitions for the strobed input channel.
// Assumes a port C that is 8 bits wide; the positions of the status bits follow the channel variant.
package strobe_in_pkg;

    typedef enum logic {
        PORT_A = 1'b0,
        PORT_B = 1'b1
    } port_sel_e;

    localparam int PC_W   = 8;
    localparam int PC_IDX = $clog2(PC_W);

    // Port C position of the interrupt status bit
    function automatic int intr_pos(port_sel_e p);
        return (p == PORT_A) ? 3 : 0;
    endfunction

    // Port C position of the buffer-full status bit
    function automatic int ibf_pos(port_sel_e p);
        return (p == PORT_A) ? 5 : 1;
    endfunction

    // Port C position of the enable bit; the set/reset command also targets this index
    function automatic int inte_pos(port_sel_e p);
        return (p == PORT_A) ? 4 : 2;
    endfunction

endpackage

// File: rtl/sip_edge.sv
// Edge detector for a strobe that idles at a known level.
// Assumes the input is synchronous to clk. The outputs compare the current level
// with the level registered at the previous edge.
module sip_edge #(
    parameter logic IDLE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic prev,
    output logic rise,
    output logic fall
);

    // Hold the level seen at the previous clock edge
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= IDLE;
        else        prev <= sig;
    end

    assign rise = sig & ~prev;
    assign fall = ~sig & prev;

endmodule

// File: rtl/sip_capture.sv
// Holding register, buffer-full flag and interrupt-pending flag.
// Assumes the edge pulses come from sip_edge instances on the same clock.
module sip_capture #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_data,
    input  logic             stb_n,
    input  logic             stb_rise,
    input  logic             stb_fall,
    input  logic             rd_fall,
    input  logic             rd_rise,
    output logic [WIDTH-1:0] held,
    output logic             full,
    output logic             pend
);

    // Follow the pins for as long as the strobe stays low
    always_ff @(posedge clk) begin
        if (!rst_n)      held <= '0;
        else if (!stb_n) held <= pin_data;
    end

    // A low strobe sets buffer-full; the end of a CPU read clears it
    always_ff @(posedge clk) begin
        if (!rst_n)       full <= 1'b0;
        else if (!stb_n)  full <= 1'b1;
        else if (rd_rise) full <= 1'b0;
    end

    // The end of a strobe arms the interrupt; the start of a read or a new strobe disarms it
    always_ff @(posedge clk) begin
        if (!rst_n)                   pend <= 1'b0;
        else if (stb_rise)            pend <= 1'b1;
        else if (rd_fall || stb_fall) pend <= 1'b0;
    end

endmodule

// File: rtl/sip_status.sv
// Interrupt-enable flip-flop and the map of status bits onto port C.
// Assumes the set/reset command is decoded upstream into a valid pulse, a bit index and a value.
module sip_status
    import strobe_in_pkg::*;
#(
    parameter port_sel_e PORT = PORT_A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [PC_IDX-1:0] cmd_bit,
    input  logic              cmd_val,
    input  logic              intr,
    input  logic              full,
    output logic              inte,
    output logic [PC_W-1:0]   pc_bits,
    output logic [PC_W-1:0]   pc_own
);

    localparam int                INTR_POS = intr_pos(PORT);
    localparam int                IBF_POS  = ibf_pos(PORT);
    localparam int                INTE_POS = inte_pos(PORT);
    localparam logic [PC_IDX-1:0] INTE_IDX = PC_IDX'(INTE_POS);

    // Load the enable only from a command that names this channel's index
    always_ff @(posedge clk) begin
        if (!rst_n)                             inte <= 1'b0;
        else if (cmd_we && cmd_bit == INTE_IDX) inte <= cmd_val;
    end

    // Place each status bit at its variant's position
    for (genvar i = 0; i < PC_W; i++) begin : g_map
        assign pc_bits[i] = (i == INTR_POS) ? intr :
                            (i == IBF_POS)  ? full :
                            (i == INTE_POS) ? inte : 1'b0;
        assign pc_own[i]  = (i == INTR_POS) || (i == IBF_POS) || (i == INTE_POS);
    end

endmodule

// File: rtl/strobe_in_port.sv
// Strobed input channel: holds a byte from the peripheral, flags it as buffer-full,
// and raises an interrupt once the strobe completes and the enable is set.
// Assumes all inputs are synchronous to clk. Address and control-word decoding happen upstream.
module strobe_in_port
    import strobe_in_pkg::*;
#(
    parameter int        WIDTH = 8,
    parameter port_sel_e PORT  = PORT_A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDTH-1:0]  pin_data,
    input  logic              stb_n,
    input  logic              rd_n,
    input  logic              cmd_we,
    input  logic [PC_IDX-1:0] cmd_bit,
    input  logic              cmd_val,
    output logic [WIDTH-1:0]  rd_data,
    output logic              ibf,
    output logic              intr,
    output logic [PC_W-1:0]   pc_bits,
    output logic [PC_W-1:0]   pc_own
);

    logic stb_prev, stb_rise, stb_fall;
    logic rd_prev, rd_rise, rd_fall;
    logic pend, inte;

    sip_edge #(.IDLE(1'b1)) u_stb_edge (
        .clk(clk), .rst_n(rst_n), .sig(stb_n),
        .prev(stb_prev), .rise(stb_rise), .fall(stb_fall)
    );

    sip_edge #(.IDLE(1'b1)) u_rd_edge (
        .clk(clk), .rst_n(rst_n), .sig(rd_n),
        .prev(rd_prev), .rise(rd_rise), .fall(rd_fall)
    );

    sip_capture #(.WIDTH(WIDTH)) u_capture (
        .clk(clk), .rst_n(rst_n), .pin_data(pin_data), .stb_n(stb_n),
        .stb_rise(stb_rise), .stb_fall(stb_fall),
        .rd_fall(rd_fall), .rd_rise(rd_rise),
        .held(rd_data), .full(ibf), .pend(pend)
    );

    // The request needs a completed strobe, a full buffer, the enable, and the strobe still high
    assign intr = pend & ibf & inte & stb_prev;

    sip_status #(.PORT(PORT)) u_status (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_bit(cmd_bit),
        .cmd_val(cmd_val), .intr(intr), .full(ibf), .inte(inte),
        .pc_bits(pc_bits), .pc_own(pc_own)
    );

    // rd_prev only feeds the edge outputs; it is kept here for visibility while debugging
    logic unused_rd_prev;
    assign unused_rd_prev = rd_prev;

endmodule

// File: rtl/strobe_in_port_chk.sv
// Properties for strobe_in_port, observed at its ports. Attached to the top module by bind.
// Assumes the synchronous active-low reset used throughout the design.
module strobe_in_port_chk
    import strobe_in_pkg::*;
#(
    parameter int        WIDTH = 8,
    parameter port_sel_e PORT  = PORT_A
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WIDTH-1:0]  pin_data,
    input logic              stb_n,
    input logic              rd_n,
    input logic              cmd_we,
    input logic [PC_IDX-1:0] cmd_bit,
    input logic              cmd_val,
    input logic [WIDTH-1:0]  rd_data,
    input logic              ibf,
    input logic              intr,
    input logic [PC_W-1:0]   pc_bits,
    input logic [PC_W-1:0]   pc_own
);

    localparam int                EN_POS = inte_pos(PORT);
    localparam logic [PC_IDX-1:0] EN_IDX = PC_IDX'(EN_POS);

    // R2
    data_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_n |=> rd_data == $past(pin_data));

    // R3
    ibf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_n |=> ibf);

    // R4
    intr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        intr |-> (ibf && pc_bits[EN_POS]));

    // R4
    intr_stb_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        intr |-> $past(stb_n));

    // R5
    rd_fall_intr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_n) && !$rose(stb_n)) |=> !intr);

    // R6
    rd_rise_ibf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_n) && stb_n) |=> !ibf);

    // R7
    inte_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_bit == EN_IDX) |=> pc_bits[EN_POS] == $past(cmd_val));

    // R7
    inte_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_we && cmd_bit == EN_IDX) |=> $stable(pc_bits[EN_POS]));

    // R8
    pc_confine_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_bits & ~pc_own) == '0);

endmodule

bind strobe_in_port strobe_in_port_chk #(.WIDTH(WIDTH), .PORT(PORT)) u_chk (
    .clk(clk), .rst_n(rst_n), .pin_data(pin_data), .stb_n(stb_n), .rd_n(rd_n),
    .cmd_we(cmd_we), .cmd_bit(cmd_bit), .cmd_val(cmd_val), .rd_data(rd_data),
    .ibf(ibf), .intr(intr), .pc_bits(pc_bits), .pc_own(pc_own)
);

// File: tb/strobe_in_port_bench.sv
// Directed bench: two instances (variant A and variant B) share one stimulus.
// Inputs change just after a falling clock edge; outputs are checked at the next falling edge.
module strobe_in_port_bench;
    import strobe_in_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_data = 8'h00;
    logic       stb_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       cmd_we = 1'b0;
    logic [2:0] cmd_bit = 3'd0;
    logic       cmd_val = 1'b0;

    logic [7:0] a_data, b_data, a_pc, b_pc, a_own, b_own;
    logic       a_ibf, b_ibf, a_intr, b_intr;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    strobe_in_port #(.WIDTH(8), .PORT(PORT_A)) u_strobe_in_port (
        .clk(clk), .rst_n(rst_n), .pin_data(pin_data), .stb_n(stb_n), .rd_n(rd_n),
        .cmd_we(cmd_we), .cmd_bit(cmd_bit), .cmd_val(cmd_val), .rd_data(a_data),
        .ibf(a_ibf), .intr(a_intr), .pc_bits(a_pc), .pc_own(a_own)
    );

    strobe_in_port #(.WIDTH(8), .PORT(PORT_B)) u_strobe_in_port_b (
        .clk(clk), .rst_n(rst_n), .pin_data(pin_data), .stb_n(stb_n), .rd_n(rd_n),
        .cmd_we(cmd_we), .cmd_bit(cmd_bit), .cmd_val(cmd_val), .rd_data(b_data),
        .ibf(b_ibf), .intr(b_intr), .pc_bits(b_pc), .pc_own(b_own)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic send_cmd(input logic [2:0] idx, input logic val);
        cmd_we = 1'b1; cmd_bit = idx; cmd_val = val;
        tick();
        cmd_we = 1'b0;
    endtask

    // R1: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        tick(); tick();
        check("R1", "A ibf/intr", {a_ibf, a_intr}, 0);
        check("R1", "B ibf/intr", {b_ibf, b_intr}, 0);
        check("R1", "A data", a_data, 8'h00);
        check("R1", "pc A/B", {a_pc, b_pc}, 0);
        rst_n = 1'b1;
        tick();
    endtask

    // R2 R3 R4 R8: strobe with the enable off, data changing within the strobe
    task automatic t_plain_strobe();
        stb_n = 1'b0; pin_data = 8'h11;
        tick();
        check("R3", "A ibf after low edge", a_ibf, 1);
        check("R2", "A data first low cycle", a_data, 8'h11);
        pin_data = 8'hA5;
        tick();
        check("R2", "A data last low cycle", a_data, 8'hA5);
        stb_n = 1'b1; pin_data = 8'hFF;
        tick();
        check("R2", "B data held after strobe", b_data, 8'hA5);
        check("R4", "intr with enable off", {a_intr, b_intr}, 0);
        check("R8", "pc A ibf at bit5", a_pc, 8'h20);
        check("R8", "pc B ibf at bit1", b_pc, 8'h02);
        check("R8", "own masks", {a_own, b_own}, 16'h3807);
    endtask

    // R5 R6: read held low for two cycles, then released
    task automatic t_read(input logic exp_intr_before);
        check("R5", "A intr before read", a_intr, exp_intr_before);
        rd_n = 1'b0;
        tick();
        check("R5", "intr cleared at read start", {a_intr, b_intr}, 0);
        check("R5", "ibf held during read", {a_ibf, b_ibf}, 2'b11);
        tick();
        check("R5", "ibf still held", {a_ibf, b_ibf}, 2'b11);
        rd_n = 1'b1;
        tick();
        check("R6", "ibf cleared at read end", {a_ibf, b_ibf}, 0);
        check("R6", "intr stays low", {a_intr, b_intr}, 0);
    endtask

    // R7: only the channel's own index loads the enable
    task automatic t_cmd();
        send_cmd(3'd3, 1'b1);
        check("R7", "index 3 ignored", {a_pc, b_pc}, 0);
        send_cmd(3'd4, 1'b1);
        check("R7", "index 4 loads A only", {a_pc, b_pc}, 16'h1000);
        send_cmd(3'd2, 1'b1);
        check("R7", "index 2 loads B only", {a_pc, b_pc}, 16'h1004);
    endtask

    // R4 R8: enabled strobe raises intr after it completes
    task automatic t_intr();
        stb_n = 1'b0; pin_data = 8'h3C;
        tick();
        check("R4", "intr low while strobe low", {a_intr, b_intr}, 0);
        tick();
        stb_n = 1'b1;
        tick();
        check("R4", "intr after strobe ends", {a_intr, b_intr}, 2'b11);
        check("R8", "pc A full layout", a_pc, 8'h38);
        check("R8", "pc B full layout", b_pc, 8'h07);
        check("R2", "data 3C", a_data, 8'h3C);
    endtask

    // R3 R10: overwrite an unread byte
    task automatic t_overwrite();
        stb_n = 1'b0; pin_data = 8'hC3;
        tick();
        check("R10", "intr drops on new strobe", {a_intr, b_intr}, 0);
        check("R3", "ibf stays set", {a_ibf, b_ibf}, 2'b11);
        check("R3", "byte replaced", a_data, 8'hC3);
        stb_n = 1'b1;
        tick();
        check("R10", "intr back after strobe", {a_intr, b_intr}, 2'b11);
    endtask

    // R9: masked request, unmasked while pending
    task automatic t_mask();
        send_cmd(3'd4, 1'b0);
        check("R7", "A enable cleared", {a_pc, b_pc}, 16'h0004);
        stb_n = 1'b0; pin_data = 8'h5A;
        tick();
        stb_n = 1'b1;
        tick();
        check("R9", "A masked, B raised", {a_intr, b_intr}, 2'b01);
        send_cmd(3'd4, 1'b1);
        check("R9", "A raised after unmask", a_intr, 1);
        check("R9", "pc A after unmask", a_pc, 8'h38);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        tick();
        t_reset();
        t_plain_strobe();
        t_read(1'b0);
        t_cmd();
        t_intr();
        t_overwrite();
        t_read(1'b1);
        t_mask();
        t_read(1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule